// File: doc/BRIEF.md
# DRAM Bank Read Transaction Sequencer

This block drives the command stream for a single read transaction to one DRAM bank. A request names a device, a bank, a row, a read count and a set of column addresses. The block opens the row with an activate command. It then issues the requested number of column reads and closes the bank with a precharge command. Every command waits until its minimum spacing rules, counted in clock cycles, are met. All timing limits are module parameters.

Each command appears as a one-cycle strobe together with its address fields. The row path carries activate and precharge, and the column path carries reads. The cycle in which a strobe is high is the timing reference for that command. A separate one-cycle strobe marks the cycle in which each read's data is due to start arriving. A done pulse marks the first cycle in which the same bank may be activated again. The next request can be accepted in that same cycle, so transactions to the bank can run back to back. Scheduling traffic to other banks or devices is left to logic outside this block.

The precharge point is the later of two deadlines: one counted from the activate, the other from the final read. A long read burst therefore pushes the precharge past the activate-based limit. The next activate is also gated twice: once from the previous activate and once from the precharge.

Top module: `rd_bank_seq`

## Requirements
- R1: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. In that same cycle `row_act_v` pulses, `row_dev`/`row_bank` carry the request's device and bank, and `row_addr` carries its row. No activate issues while `req_valid` is low.
- R2: The first read (`col_rd_v`) issues exactly T_RCD cycles after the activate. It carries the captured device and bank, and column field 0 (`req_cols` bits [COL_W-1:0]).
- R3: Read k (k counted from 0) issues exactly T_RCD + k*T_CC cycles after the activate and uses column field k (`req_cols` bits [k*COL_W +: COL_W]). Exactly `req_ncol` reads issue, where `req_ncol` is a plain binary count from 1 to MAX_RD.
- R4: `data_exp` is high exactly T_CAC cycles after each read strobe and in no other cycle.
- R5: The precharge (`row_pre_v`) issues at the later of two points: activate + T_RAS, and last read + T_RDP. It carries the captured device and bank. With the default parameters it falls 20 cycles after the activate for 1 to 3 reads, and 24 cycles after for 4 reads.
- R6: `done` pulses for one cycle at the later of two points: activate + T_RC, and precharge + T_RP. In that cycle `req_ready` is high, so a new activate may issue. With the default parameters this is 28 cycles after the activate for 1 to 3 reads, and 32 cycles after for 4 reads.
- R7: `req_ready` stays low from the cycle after an activate until the `done` cycle. A request held valid during that time starts nothing early.
- R8: While `rst_n` is low, all command strobes, `data_exp` and `done` are low, `req_ready` is high, and no data strobe owed by a read issued before the reset appears afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_dev | input | DEV_W | Device address |
| req_bank | input | BANK_W | Bank address |
| req_row | input | ROW_W | Row address |
| req_ncol | input | $clog2(MAX_RD+1) | Number of reads, 1 to MAX_RD |
| req_cols | input | MAX_RD*COL_W | Column addresses, field k for read k |
| row_act_v | output | 1 | Activate strobe |
| row_pre_v | output | 1 | Precharge strobe |
| row_dev | output | DEV_W | Device field of the row command |
| row_bank | output | BANK_W | Bank field of the row command |
| row_addr | output | ROW_W | Row field of the activate |
| col_rd_v | output | 1 | Read strobe |
| col_dev | output | DEV_W | Device field of the read |
| col_bank | output | BANK_W | Bank field of the read |
| col_addr | output | COL_W | Column field of the read |
| data_exp | output | 1 | Read data due to start this cycle |
| done | output | 1 | Bank may be activated again |

## Verification
The assertions assume that every accepted request carries a read count between 1 and MAX_RD, and one of them checks this at the request port. They also assume that all timing parameters are at least 1, because the spacing checks compare elapsed-cycle counters against these limits. The stimulus table uses only read counts 1 to 4 and never drives a count outside that range. It holds each request valid until it is accepted, which exercises both the back-to-back start and the refusal while the bank is busy. The mid-transaction reset is applied only after the reset sequence has settled, so the elapsed-cycle counters are always cleared first.

// File: rtl/rd_bank_seq.sv
module rd_bank_seq #(
  parameter int DEV_W  = 5,
  parameter int BANK_W = 4,
  parameter int ROW_W  = 9,
  parameter int COL_W  = 6,
  parameter int MAX_RD = 4,
  parameter int T_RCD  = 7,
  parameter int T_CC   = 4,
  parameter int T_CAC  = 8,
  parameter int T_RAS  = 20,
  parameter int T_RDP  = 5,
  parameter int T_RC   = 28,
  parameter int T_RP   = 8,
  localparam int NW    = $clog2(MAX_RD + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [DEV_W-1:0]        req_dev,
  input  logic [BANK_W-1:0]       req_bank,
  input  logic [ROW_W-1:0]        req_row,
  input  logic [NW-1:0]           req_ncol,
  input  logic [MAX_RD*COL_W-1:0] req_cols,
  output logic                    row_act_v,
  output logic                    row_pre_v,
  output logic [DEV_W-1:0]        row_dev,
  output logic [BANK_W-1:0]       row_bank,
  output logic [ROW_W-1:0]        row_addr,
  output logic                    col_rd_v,
  output logic [DEV_W-1:0]        col_dev,
  output logic [BANK_W-1:0]       col_bank,
  output logic [COL_W-1:0]        col_addr,
  output logic                    data_exp,
  output logic                    done
);
  localparam int IW = (MAX_RD > 1) ? $clog2(MAX_RD) : 1;
  localparam int M1 = (T_RC > T_RAS) ? T_RC : T_RAS;
  localparam int M2 = (M1 > T_RP) ? M1 : T_RP;
  localparam int M3 = (M2 > T_RCD) ? M2 : T_RCD;
  localparam int M4 = (M3 > T_RDP) ? M3 : T_RDP;
  localparam int TMAX = (M4 > T_CC) ? M4 : T_CC;
  localparam int TW = $clog2(TMAX + 1);
  localparam int SW = TW + 1;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_PRE, S_WAIT} st_t;

  st_t st;
  logic [TW-1:0] rcd_c, cc_c, ras_c, rdp_c, rc_c, rp_c;
  logic [DEV_W-1:0]  dev_q;
  logic [BANK_W-1:0] bank_q;
  logic [IW-1:0]     rd_idx, last_q;
  logic [COL_W-1:0]  cols_q [MAX_RD];
  logic [T_CAC-1:0]  dq;

  function automatic logic [TW-1:0] tick(input logic ld, input int t, input logic [TW-1:0] c);
    if (ld) return TW'(t - 1);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  assign done      = (st == S_WAIT) && rc_c == '0 && rp_c == '0;
  assign req_ready = (st == S_IDLE) || done;
  assign row_act_v = req_ready && req_valid;
  assign col_rd_v  = (st == S_RD) && rcd_c == '0 && cc_c == '0;
  assign row_pre_v = (st == S_PRE) && ras_c == '0 && rdp_c == '0;
  assign row_dev   = row_act_v ? req_dev : dev_q;
  assign row_bank  = row_act_v ? req_bank : bank_q;
  assign row_addr  = req_row;
  assign col_dev   = dev_q;
  assign col_bank  = bank_q;
  assign col_addr  = cols_q[rd_idx];
  assign data_exp  = dq[T_CAC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcd_c <= '0; cc_c <= '0; ras_c <= '0;
      rdp_c <= '0; rc_c <= '0; rp_c  <= '0;
    end else begin
      rcd_c <= tick(row_act_v, T_RCD, rcd_c);
      ras_c <= tick(row_act_v, T_RAS, ras_c);
      rc_c  <= tick(row_act_v, T_RC,  rc_c);
      cc_c  <= tick(col_rd_v,  T_CC,  cc_c);
      rdp_c <= tick(col_rd_v,  T_RDP, rdp_c);
      rp_c  <= tick(row_pre_v, T_RP,  rp_c);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dev_q  <= '0;
      bank_q <= '0;
      rd_idx <= '0;
      last_q <= '0;
      for (int i = 0; i < MAX_RD; i++) cols_q[i] <= '0;
    end else begin
      unique case (st)
        S_IDLE, S_WAIT: if (row_act_v) st <= S_RD;
                        else if (done) st <= S_IDLE;
        S_RD:           if (col_rd_v && rd_idx == last_q) st <= S_PRE;
        S_PRE:          if (row_pre_v) st <= S_WAIT;
        default:        st <= S_IDLE;
      endcase
      if (row_act_v) begin
        dev_q  <= req_dev;
        bank_q <= req_bank;
        last_q <= IW'(req_ncol - NW'(1));
        rd_idx <= '0;
        for (int i = 0; i < MAX_RD; i++) cols_q[i] <= req_cols[i*COL_W +: COL_W];
      end else if (col_rd_v) begin
        rd_idx <= rd_idx + 1'b1;
      end
    end
  end

  generate
    if (T_CAC == 1) begin : g_dq1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) dq <= '0; else dq <= col_rd_v;
    end else begin : g_dqn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) dq <= '0; else dq <= {dq[T_CAC-2:0], col_rd_v};
    end
  endgenerate

  logic [SW-1:0] since_act, since_rd, since_pre;
  logic          seen_rd, had_act;

  function automatic logic [SW-1:0] age(input logic ev, input logic [SW-1:0] c);
    if (ev) return SW'(1);
    return (&c) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= '0; since_rd <= '0; since_pre <= '0;
      seen_rd <= 1'b0; had_act <= 1'b0;
    end else begin
      since_act <= age(row_act_v, since_act);
      since_rd  <= age(col_rd_v, since_rd);
      since_pre <= age(row_pre_v, since_pre);
      seen_rd   <= row_act_v ? 1'b0 : (col_rd_v ? 1'b1 : seen_rd);
      had_act   <= had_act | row_act_v;
    end
  end

  p_rcd_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    col_rd_v && !seen_rd |-> since_act >= SW'(T_RCD));
  p_cc_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    col_rd_v && seen_rd |-> since_rd >= SW'(T_CC));
  p_ncol_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    row_act_v |-> req_ncol >= NW'(1) && req_ncol <= NW'(MAX_RD));
  p_pre_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    row_pre_v |-> seen_rd && since_act >= SW'(T_RAS) && since_rd >= SW'(T_RDP));
  p_act_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    row_act_v && had_act |-> since_act >= SW'(T_RC) && since_pre >= SW'(T_RP));
  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    row_act_v |=> !req_ready);
endmodule

// File: tb/sim_rd_bank_seq.sv
`timescale 1ns/100ps
module sim_rd_bank_seq;
  localparam int DW = 5, BW = 4, RW = 9, CW = 6, MR = 4;
  localparam int T_RCD = 7, T_CC = 4, T_CAC = 8, T_RAS = 20, T_RDP = 5, T_RC = 28, T_RP = 8;
  localparam int NV = 6;
  // {read count, precharge offset, done offset}
  localparam logic [23:0] VEC [NV] = '{24'h01_14_1C, 24'h04_18_20, 24'h02_14_1C,
                                       24'h03_14_1C, 24'h04_18_20, 24'h01_14_1C};

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic req_ready, row_act_v, row_pre_v, col_rd_v, data_exp, done;
  logic [DW-1:0] req_dev = '0, row_dev, col_dev;
  logic [BW-1:0] req_bank = '0, row_bank, col_bank;
  logic [RW-1:0] req_row = '0, row_addr;
  logic [2:0]    req_ncol = 3'd1;
  logic [MR*CW-1:0] req_cols = '0;
  logic [CW-1:0] col_addr;

  always #2.5 clk = ~clk;

  rd_bank_seq #(.DEV_W(DW), .BANK_W(BW), .ROW_W(RW), .COL_W(CW), .MAX_RD(MR),
    .T_RCD(T_RCD), .T_CC(T_CC), .T_CAC(T_CAC), .T_RAS(T_RAS), .T_RDP(T_RDP),
    .T_RC(T_RC), .T_RP(T_RP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dev(req_dev), .req_bank(req_bank), .req_row(req_row), .req_ncol(req_ncol),
    .req_cols(req_cols), .row_act_v(row_act_v), .row_pre_v(row_pre_v),
    .row_dev(row_dev), .row_bank(row_bank), .row_addr(row_addr), .col_rd_v(col_rd_v),
    .col_dev(col_dev), .col_bank(col_bank), .col_addr(col_addr),
    .data_exp(data_exp), .done(done));

  int errs = 0, checks = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  int nx_n, nx_pre, nx_nxt, nx_dev, nx_bank, nx_row;
  logic [CW-1:0] nx_cols [MR];
  int act_t, m_n, m_pre, m_nxt, m_dev, m_bank, rd_k, wp;
  logic [CW-1:0] m_cols [MR];
  bit busy, bad_ready;
  int rt [16];
  bit rtv [16];

  always @(negedge clk) begin : mon
    bit e;
    if (!rst_n) begin
      busy = 0;
      for (int i = 0; i < 16; i++) rtv[i] = 0;
    end else begin
      e = 0;
      for (int i = 0; i < 16; i++)
        if (rtv[i] && rt[i] + T_CAC == cyc) begin e = 1; rtv[i] = 0; end
      if (e || data_exp) chk(data_exp == e, "R4", "data strobe", int'(data_exp), int'(e));
      if (busy && !done && req_ready) bad_ready = 1;
      if (done) begin
        chk(busy && cyc == act_t + m_nxt, "R6", "done offset", cyc - act_t, m_nxt);
        chk(!bad_ready, "R7", "ready while busy", int'(bad_ready), 0);
        busy = 0;
      end
      if (col_rd_v) begin
        chk(busy && cyc == act_t + T_RCD + rd_k * T_CC, rd_k == 0 ? "R2" : "R3",
            "read offset", cyc - act_t, T_RCD + rd_k * T_CC);
        chk(rd_k < MR && col_addr == m_cols[rd_k % MR], "R3", "read column",
            int'(col_addr), int'(m_cols[rd_k % MR]));
        chk(col_dev == DW'(m_dev) && col_bank == BW'(m_bank), "R2", "read dev/bank",
            int'({col_dev, col_bank}), (m_dev << BW) | m_bank);
        rt[wp] = cyc; rtv[wp] = 1; wp = (wp + 1) % 16;
        rd_k++;
      end
      if (row_pre_v) begin
        chk(busy && cyc == act_t + m_pre, "R5", "precharge offset", cyc - act_t, m_pre);
        chk(rd_k == m_n, "R3", "read count", rd_k, m_n);
        chk(row_dev == DW'(m_dev) && row_bank == BW'(m_bank), "R5", "precharge dev/bank",
            int'({row_dev, row_bank}), (m_dev << BW) | m_bank);
      end
      if (row_act_v) begin
        chk(!busy, "R7", "activate while busy", int'(busy), 0);
        chk(row_dev == DW'(nx_dev) && row_bank == BW'(nx_bank) && row_addr == RW'(nx_row),
            "R1", "activate fields", int'({row_dev, row_bank, row_addr}),
            (((nx_dev << BW) | nx_bank) << RW) | nx_row);
        act_t = cyc; m_n = nx_n; m_pre = nx_pre; m_nxt = nx_nxt;
        m_dev = nx_dev; m_bank = nx_bank;
        for (int i = 0; i < MR; i++) m_cols[i] = nx_cols[i];
        busy = 1; bad_ready = 0; rd_k = 0;
      end
    end
  end

  task automatic send(input int v, input int n, input int pre, input int nxt);
    @(posedge clk); #1;
    nx_n = n; nx_pre = pre; nx_nxt = nxt;
    nx_dev = (v + 3) % 32; nx_bank = v % 16; nx_row = (v * 37 + 1) % 512;
    for (int i = 0; i < MR; i++) begin
      nx_cols[i] = CW'((v * 11 + i * 7 + 3) & 63);
      req_cols[i*CW +: CW] = nx_cols[i];
    end
    req_dev = DW'(nx_dev); req_bank = BW'(nx_bank); req_row = RW'(nx_row);
    req_ncol = 3'(n); req_valid = 1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  initial begin
    int hits;
    wp = 0;
    repeat (3) @(negedge clk);
    chk({row_act_v, row_pre_v, col_rd_v, data_exp, done, req_ready} == 6'b000001,
        "R8", "reset outputs", int'({row_act_v, row_pre_v, col_rd_v, data_exp, done, req_ready}), 1);
    @(posedge clk); #1 rst_n = 1;
    hits = 0;
    repeat (6) begin @(negedge clk); if (row_act_v || !req_ready) hits++; end
    chk(hits == 0, "R1", "idle without valid", hits, 0);

    for (int v = 0; v < NV; v++)
      send(v, int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]));
    repeat (40) @(negedge clk);

    // reset in the middle of a four-read transaction, with data still owed
    send(9, 4, 24, 32);
    repeat (12) @(negedge clk);
    @(posedge clk); #1 rst_n = 0;
    @(negedge clk);
    chk({row_act_v, row_pre_v, col_rd_v, data_exp, done, req_ready} == 6'b000001,
        "R8", "mid-run reset outputs", int'({row_act_v, row_pre_v, col_rd_v, data_exp, done, req_ready}), 1);
    @(posedge clk); #1 rst_n = 1;
    hits = 0;
    repeat (14) begin @(negedge clk); if (data_exp || col_rd_v || row_pre_v) hits++; end
    chk(hits == 0, "R8", "stale strobes after reset", hits, 0);

    send(12, 2, 20, 28);
    repeat (40) @(negedge clk);
    send(13, 4, 24, 32);
    repeat (40) @(negedge clk);
    wrap_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
    wrap_up();
  end
endmodule